// File: doc/BRIEF.md
# Serial Control Register Port

This block is a four-wire serial slave that gives a host access to a small bank of 8-bit control registers. The host pulls the active-low select low, toggles a serial clock that rests high, and shifts a two-byte frame into the data input with the most significant bit first. The first byte is a command. Its top bit selects the direction, and its low nibble selects the register. The second byte carries the register value. For a write the host supplies that value. For a read the block returns it on the serial data output.

The serial pins are brought into the system clock domain through synchronising flip-flops, and all frame decoding runs on the system clock. The register contents are exposed as one flat parallel output so that neighbouring logic can use them directly. The serial side has no stream traffic, so every pin is a plain control or data wire with no valid/ready handshake and no back-pressure. The host paces the transfer entirely through the serial clock, which must be slow enough that each level lasts several system clocks.

Top module: `spi_regport`

## Requirements
- R1: After reset, all five registers read 0x00 on `ctrl_regs` and `sdo` is low.
- R2: A frame whose command bit 7 is 0 writes the second byte (MSB first, sampled on rising `sclk`) into the register named by command bits 3:0. The new value appears on `ctrl_regs` (register n at bits 8n+7:8n) by the fourth rising `clk` edge after the 16th rising `sclk` edge.
- R3: A frame whose command bit 7 is 1 returns the addressed register on `sdo` during the second byte, MSB first. Each bit changes after a falling `sclk` edge and is valid at the following rising edge. A read changes no register.
- R4: Command bits 6:4 have no effect on either the direction or the address.
- R5: A write to an address from 5 to 15 changes no register, and a read from such an address returns 0x00.
- R6: If `cs_n` rises before the 16th rising `sclk` edge, the frame is dropped and no register changes.
- R7: `sdo` is low while `cs_n` is high, and it is also low throughout a write frame.
- R8: A write changes only the addressed register. The other four keep their values.
- R9: Rising `sclk` edges after the 16th in the same select window are ignored. The value already written stays as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host, idles high |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial command/data input |
| sdo | output | 1 | Serial read data output |
| ctrl_regs | output | 40 | Register bank, register n at bits 8n+7:8n |

## Verification
A serial pin change shows up after two synchroniser stages and one edge-detect stage, so a written value reaches `ctrl_regs` on the fourth system clock edge after the 16th rising `sclk` edge. The bench samples the bank exactly four edges after driving that edge, on a falling `clk` edge, and compares it with its model. Read bits are launched about three system clocks after a falling `sclk` edge. The bench holds each serial level for eight system clocks and reads `sdo` just before it raises `sclk`, which keeps each sample well clear of the transition. `sdo` is also checked on the cycle right after `cs_n` rises, and through every bit of the write frames.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  parameter int unsigned RP_DW   = 8;
  parameter int unsigned RP_AW   = 4;
  parameter int unsigned RP_NREG = 5;
  parameter int unsigned RP_SYNC = 2;

  typedef enum logic {
    XFER_WRITE = 1'b0,
    XFER_READ  = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_regport_pkg::*;
#(
  parameter int unsigned DW = RP_DW,
  parameter int unsigned AW = RP_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_s,
  input  logic          cs_s,
  input  logic          sdi_s,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          sdo_r
);
  localparam int unsigned FRAME = 2 * DW;
  localparam int unsigned CW    = $clog2(FRAME + 1);
  localparam logic [CW-1:0] CMD_LAST  = CW'(DW - 1);
  localparam logic [CW-1:0] DATA_LAST = CW'(FRAME - 1);
  localparam logic [CW-1:0] DATA_FIRST = CW'(DW);
  localparam logic [CW-1:0] FULL = CW'(FRAME);

  logic          sclk_d;
  logic          rise, fall;
  logic [CW-1:0] bitcnt;
  logic [DW-1:0] sh, nxt, osh;
  xfer_dir_e     dir;
  logic [AW-1:0] addr;

  assign rise    = sclk_s & ~sclk_d;
  assign fall    = ~sclk_s & sclk_d;
  assign nxt     = {sh[DW-2:0], sdi_s};
  assign rd_addr = nxt[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b1;
      bitcnt  <= '0;
      sh      <= '0;
      osh     <= '0;
      dir     <= XFER_WRITE;
      addr    <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      sdo_r   <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      wr_en  <= 1'b0;
      if (cs_s) begin
        bitcnt <= '0;
        sh     <= '0;
        dir    <= XFER_WRITE;
        sdo_r  <= 1'b0;
      end else if (rise && bitcnt < FULL) begin
        sh     <= nxt;
        bitcnt <= bitcnt + 1'b1;
        if (bitcnt == CMD_LAST) begin
          dir  <= xfer_dir_e'(nxt[DW-1]);
          addr <= nxt[AW-1:0];
          osh  <= nxt[DW-1] ? rd_data : '0;
        end
        if (bitcnt == DATA_LAST && dir == XFER_WRITE) begin
          wr_en   <= 1'b1;
          wr_addr <= addr;
          wr_data <= nxt;
        end
      end else if (fall && dir == XFER_READ && bitcnt >= DATA_FIRST && bitcnt < FULL) begin
        sdo_r <= osh[DW-1];
        osh   <= {osh[DW-2:0], 1'b0};
      end
    end
  end

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= FULL);
  assert_tail_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && bitcnt == FULL) |=> $stable(sh));
  assert_write_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  assert_deselect_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (bitcnt == '0 && !sdo_r));
  assert_write_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dir == XFER_WRITE && !$past(sdo_r)) |=> !sdo_r);
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_regport_pkg::*;
#(
  parameter int unsigned DW   = RP_DW,
  parameter int unsigned AW   = RP_AW,
  parameter int unsigned NREG = RP_NREG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic [AW-1:0]      rd_addr,
  output logic [DW-1:0]      rd_data,
  output logic [NREG*DW-1:0] q_flat
);
  logic [DW-1:0] q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= '0;
      else if (wr_en && wr_addr == AW'(i)) q[i] <= wr_data;
    end
    assign q_flat[i*DW +: DW] = q[i];

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == AW'(i)) |=> q[i] == $past(wr_data));
    assert_others_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == AW'(i)) |=> $stable(q[i]));
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr == AW'(i)) rd_data = q[i];
  end

  assert_high_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= AW'(NREG)) |=> $stable(q_flat));
  assert_no_stray_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q_flat));
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int unsigned DW   = RP_DW,
  parameter int unsigned AW   = RP_AW,
  parameter int unsigned NREG = RP_NREG,
  parameter int unsigned SYNC = RP_SYNC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               cs_n,
  input  logic               sdi,
  output logic               sdo,
  output logic [NREG*DW-1:0] ctrl_regs
);
  logic          sclk_s, cs_s, sdi_s;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;
  logic          wr_en, sdo_r;

  spi_pin_sync #(.W(3), .STAGES(SYNC), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sclk, cs_n, sdi}),
    .q({sclk_s, cs_s, sdi_s})
  );

  spi_frame_ctrl #(.DW(DW), .AW(AW)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .cs_s(cs_s), .sdi_s(sdi_s),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sdo_r(sdo_r)
  );

  spi_reg_bank #(.DW(DW), .AW(AW), .NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .q_flat(ctrl_regs)
  );

  assign sdo = sdo_r & ~cs_n;
endmodule

// File: tb/spi_regport_test.sv
module spi_regport_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1;
  logic cs_n = 1'b1;
  logic sdi = 1'b0;
  logic sdo;
  logic [39:0] ctrl_regs;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [7:0] mdl [5];
  logic [39:0] snap;
  bit sdo_seen;

  always #10 clk = ~clk;

  spi_regport uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .ctrl_regs(ctrl_regs)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] model_flat();
    logic [39:0] f;
    for (int i = 0; i < 5; i++) f[i*8 +: 8] = mdl[i];
    return f;
  endfunction

  function automatic void model_apply(input logic [7:0] cmd, input logic [7:0] dat);
    if (!cmd[7] && cmd[3:0] < 4'd5) mdl[cmd[3:0]] = dat;
  endfunction

  function automatic logic [7:0] model_read(input logic [7:0] cmd);
    return (cmd[3:0] < 4'd5) ? mdl[cmd[3:0]] : 8'h00;
  endfunction

  // nbits rising edges in one select window; returns the byte seen on sdo in bits 9..16
  task automatic frame(input logic [7:0] cmd, input logic [7:0] dat, input int nbits,
                       output logic [7:0] got);
    logic [15:0] w;
    w = {cmd, dat};
    got = '0;
    sdo_seen = 0;
    snap = ctrl_regs;
    cs_n = 1'b0;
    tick(8);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      sdi = (i < 16) ? w[15-i] : 1'b0;
      tick(8);
      if (i >= 8 && i < 16) got = {got[6:0], sdo};
      if (sdo === 1'b1 && (i < 8 || !cmd[7])) sdo_seen = 1;
      sclk = 1'b1;
      if (i == 15) begin
        tick(4);
        snap = ctrl_regs;
        tick(4);
      end else begin
        tick(8);
      end
    end
    cs_n = 1'b1;
    tick(1);
    chk("R7 sdo low after deselect", {39'd0, sdo}, 40'd0);
    tick(8);
  endtask

  initial begin
    logic [7:0] got, cmd, dat;
    void'($urandom(32'd2718));
    for (int i = 0; i < 5; i++) mdl[i] = 8'h00;
    tick(3);
    chk("R1 reset regs", ctrl_regs, 40'd0);
    chk("R1 reset sdo", {39'd0, sdo}, 40'd0);
    rst_n = 1'b1;
    tick(4);

    // R2/R8: directed writes with the 4-edge deadline
    for (int a = 0; a < 5; a++) begin
      cmd = 8'(a);
      dat = 8'hA1 + 8'(a * 17);
      frame(cmd, dat, 16, got);
      model_apply(cmd, dat);
      chk("R2 value by 4th clk edge", snap, model_flat());
      chk("R8 bank after write", ctrl_regs, model_flat());
      chk("R7 sdo quiet in write frame", {39'd0, sdo_seen}, 40'd0);
    end

    // R3: reads of each register
    for (int a = 0; a < 5; a++) begin
      cmd = 8'h80 | 8'(a);
      frame(cmd, 8'h5A, 16, got);
      chk("R3 read data", {32'd0, got}, {32'd0, model_read(cmd)});
      chk("R3 read leaves bank", ctrl_regs, model_flat());
    end

    // R4: bits 6:4 set on write and read
    frame(8'h72, 8'h3C, 16, got);
    model_apply(8'h72, 8'h3C);
    chk("R4 write with bits 6:4", ctrl_regs, model_flat());
    frame(8'hF2, 8'h00, 16, got);
    chk("R4 read with bits 6:4", {32'd0, got}, 40'h3C);

    // R5: high addresses
    frame(8'h09, 8'hFF, 16, got);
    chk("R5 high write ignored", ctrl_regs, model_flat());
    frame(8'h8C, 8'h00, 16, got);
    chk("R5 high read zero", {32'd0, got}, 40'd0);
    frame(8'h85, 8'h00, 16, got);
    chk("R5 addr 5 read zero", {32'd0, got}, 40'd0);

    // R6: aborted frames
    frame(8'h01, 8'h77, 12, got);
    chk("R6 abort after 12 bits", ctrl_regs, model_flat());
    frame(8'h03, 8'h00, 15, got);
    chk("R6 abort after 15 bits", ctrl_regs, model_flat());

    // R9: trailing edges
    frame(8'h04, 8'hC3, 20, got);
    model_apply(8'h04, 8'hC3);
    chk("R9 extra edges ignored", ctrl_regs, model_flat());

    // random mix
    for (int k = 0; k < 50; k++) begin
      cmd = 8'($urandom);
      dat = 8'($urandom);
      frame(cmd, dat, 16, got);
      if (cmd[7]) chk("R3 random read", {32'd0, got}, {32'd0, model_read(cmd)});
      model_apply(cmd, dat);
      chk("R8 random bank", ctrl_regs, model_flat());
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule